// File: doc/BRIEF.md
# Two-Source SPI Command Arbiter

This block lets two independent SPI command producers share one execution engine. Each producer side carries four valid/ready streams. Commands and transmit data flow toward the engine. Received data and sync responses flow back from it. Only one producer at a time holds the engine. That producer keeps it for a whole burst of commands and gives it up only when the engine's sync response for its transaction has been accepted. After that, the channel spends one cycle idle before it can be granted again.

A producer that does not hold the channel sees every ready signal toward it held low, and sees no valid on the return streams. Its command and transmit-data valids are not forwarded to the engine, so it stalls until it is granted. Once a producer holds the channel, all four of its streams are plain wires to the engine. A burst of N commands from one producer therefore occupies the engine for at least 2+N cycles.

Top module: `spi_cmd_arbiter`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, no producer owns the channel: every ready toward s0/s1 is 0, and m_cmd_valid, m_sdo_valid, s0/s1_sdi_valid and s0/s1_sync_valid are 0.
- R2: When the channel is idle and a producer raises cmd_valid, m_cmd_valid stays 0 in that cycle. In the next cycle, m_cmd_valid is 1, m_cmd_data carries that producer's command and its cmd_ready is 1.
- R3: The owner's command passes to m in the same cycle, one command per cycle back to back. The owner's cmd_ready equals m_cmd_ready.
- R4: If s0 and s1 both raise cmd_valid in the same idle cycle, s0 is granted first.
- R5: Toward the producer that does not own the channel, cmd_ready, sdo_ready and sdi_ready are 0, and sdi_valid and sync_valid are 0.
- R6: m_sync_valid and m_sync_data reach the owner in the same cycle, and m_sync_ready equals the owner's sync_ready. A command from the owner is still forwarded in the cycle in which the sync handshake completes.
- R7: The cycle after a sync handshake (m_sync_valid and m_sync_ready both 1) is idle: m_cmd_valid is 0 even when a producer is requesting. The grant then follows as in R2.
- R8: For the owner, the sdo stream (valid, data, ready) and the sdi stream pass through in the same cycle. A non-owner's pending sdo valid is forwarded once it gains ownership.
- R9: Ownership does not change while m_sync_valid is 1 and m_sync_ready is 0, or while no sync response arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s0_cmd_valid | input | 1 | Source 0 command valid |
| s0_cmd_ready | output | 1 | Source 0 command ready |
| s0_cmd_data | input | CMD_W | Source 0 command word |
| s0_sdo_valid | input | 1 | Source 0 transmit data valid |
| s0_sdo_ready | output | 1 | Source 0 transmit data ready |
| s0_sdo_data | input | SDO_W | Source 0 transmit data |
| s0_sdi_valid | output | 1 | Received data valid toward source 0 |
| s0_sdi_ready | input | 1 | Source 0 accepts received data |
| s0_sdi_data | output | SDI_W | Received data toward source 0 |
| s0_sync_valid | output | 1 | Sync response valid toward source 0 |
| s0_sync_ready | input | 1 | Source 0 accepts sync response |
| s0_sync_data | output | SYNC_W | Sync response toward source 0 |
| s1_cmd_valid | input | 1 | Source 1 command valid |
| s1_cmd_ready | output | 1 | Source 1 command ready |
| s1_cmd_data | input | CMD_W | Source 1 command word |
| s1_sdo_valid | input | 1 | Source 1 transmit data valid |
| s1_sdo_ready | output | 1 | Source 1 transmit data ready |
| s1_sdo_data | input | SDO_W | Source 1 transmit data |
| s1_sdi_valid | output | 1 | Received data valid toward source 1 |
| s1_sdi_ready | input | 1 | Source 1 accepts received data |
| s1_sdi_data | output | SDI_W | Received data toward source 1 |
| s1_sync_valid | output | 1 | Sync response valid toward source 1 |
| s1_sync_ready | input | 1 | Source 1 accepts sync response |
| s1_sync_data | output | SYNC_W | Sync response toward source 1 |
| m_cmd_valid | output | 1 | Command valid to engine |
| m_cmd_ready | input | 1 | Engine accepts command |
| m_cmd_data | output | CMD_W | Command word to engine |
| m_sdo_valid | output | 1 | Transmit data valid to engine |
| m_sdo_ready | input | 1 | Engine accepts transmit data |
| m_sdo_data | output | SDO_W | Transmit data to engine |
| m_sdi_valid | input | 1 | Received data valid from engine |
| m_sdi_ready | output | 1 | Received data accepted |
| m_sdi_data | input | SDI_W | Received data from engine |
| m_sync_valid | input | 1 | Sync response valid from engine |
| m_sync_ready | output | 1 | Sync response accepted |
| m_sync_data | input | SYNC_W | Sync response from engine |

## Verification
Two events can share a cycle: the sync handshake that ends ownership, and a command from the owner. A third can join them, a request from the other producer that is already waiting. The bench builds that cycle on purpose: s0 holds a command and its sync_ready high while the engine raises m_sync_valid, and s1 is already requesting. The bench then checks three things. The owner's command still leaves in that cycle. The next cycle shows m_cmd_valid low. When both producers are still requesting after the idle cycle, s0 wins again, ahead of the waiting s1. A scoreboard queue of the expected command words confirms that every command reaches the engine exactly once and in order.

// File: rtl/spi_arb_pkg.sv
package spi_arb_pkg;
  typedef enum logic [1:0] {
    OWN_NONE = 2'd0,
    OWN_S0   = 2'd1,
    OWN_S1   = 2'd2
  } owner_t;
endpackage

// File: rtl/spi_arb_owner_fsm.sv
module spi_arb_owner_fsm
  import spi_arb_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   req0,
  input  logic   req1,
  input  logic   sync_done,
  output owner_t owner_q
);
  owner_t owner_d;
  logic   owner_en;

  always_comb begin
    owner_d  = owner_q;
    owner_en = 1'b0;
    unique case (owner_q)
      OWN_NONE: begin
        // fixed priority: source 0 wins a tie
        if (req0) begin
          owner_d  = OWN_S0;
          owner_en = 1'b1;
        end else if (req1) begin
          owner_d  = OWN_S1;
          owner_en = 1'b1;
        end
      end
      OWN_S0, OWN_S1: begin
        if (sync_done) begin
          owner_d  = OWN_NONE;
          owner_en = 1'b1;
        end
      end
      default: begin
        owner_d  = OWN_NONE;
        owner_en = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owner_q <= OWN_NONE;
    end else if (owner_en) begin
      owner_q <= owner_d;
    end
  end
endmodule

// File: rtl/spi_arb_fwd_mux.sv
module spi_arb_fwd_mux #(
  parameter int W = 8
) (
  input  logic         sel0,
  input  logic         sel1,
  input  logic         in0_valid,
  output logic         in0_ready,
  input  logic [W-1:0] in0_data,
  input  logic         in1_valid,
  output logic         in1_ready,
  input  logic [W-1:0] in1_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  always_comb begin
    out_valid = (sel0 & in0_valid) | (sel1 & in1_valid);
    out_data  = sel1 ? in1_data : in0_data;
    in0_ready = sel0 & out_ready;
    in1_ready = sel1 & out_ready;
  end
endmodule

// File: rtl/spi_arb_ret_demux.sv
module spi_arb_ret_demux #(
  parameter int W = 8
) (
  input  logic         sel0,
  input  logic         sel1,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out0_valid,
  input  logic         out0_ready,
  output logic [W-1:0] out0_data,
  output logic         out1_valid,
  input  logic         out1_ready,
  output logic [W-1:0] out1_data
);
  always_comb begin
    out0_valid = sel0 & in_valid;
    out1_valid = sel1 & in_valid;
    out0_data  = in_data;
    out1_data  = in_data;
    in_ready   = (sel0 & out0_ready) | (sel1 & out1_ready);
  end
endmodule

// File: rtl/spi_cmd_arbiter.sv
module spi_cmd_arbiter
  import spi_arb_pkg::*;
#(
  parameter int CMD_W  = 16,
  parameter int SDO_W  = 8,
  parameter int SDI_W  = 8,
  parameter int SYNC_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s0_cmd_valid,
  output logic              s0_cmd_ready,
  input  logic [CMD_W-1:0]  s0_cmd_data,
  input  logic              s0_sdo_valid,
  output logic              s0_sdo_ready,
  input  logic [SDO_W-1:0]  s0_sdo_data,
  output logic              s0_sdi_valid,
  input  logic              s0_sdi_ready,
  output logic [SDI_W-1:0]  s0_sdi_data,
  output logic              s0_sync_valid,
  input  logic              s0_sync_ready,
  output logic [SYNC_W-1:0] s0_sync_data,
  input  logic              s1_cmd_valid,
  output logic              s1_cmd_ready,
  input  logic [CMD_W-1:0]  s1_cmd_data,
  input  logic              s1_sdo_valid,
  output logic              s1_sdo_ready,
  input  logic [SDO_W-1:0]  s1_sdo_data,
  output logic              s1_sdi_valid,
  input  logic              s1_sdi_ready,
  output logic [SDI_W-1:0]  s1_sdi_data,
  output logic              s1_sync_valid,
  input  logic              s1_sync_ready,
  output logic [SYNC_W-1:0] s1_sync_data,
  output logic              m_cmd_valid,
  input  logic              m_cmd_ready,
  output logic [CMD_W-1:0]  m_cmd_data,
  output logic              m_sdo_valid,
  input  logic              m_sdo_ready,
  output logic [SDO_W-1:0]  m_sdo_data,
  input  logic              m_sdi_valid,
  output logic              m_sdi_ready,
  input  logic [SDI_W-1:0]  m_sdi_data,
  input  logic              m_sync_valid,
  output logic              m_sync_ready,
  input  logic [SYNC_W-1:0] m_sync_data
);
  owner_t owner_q;
  logic   sel0;
  logic   sel1;
  logic   sync_done;

  assign sel0      = (owner_q == OWN_S0);
  assign sel1      = (owner_q == OWN_S1);
  assign sync_done = m_sync_valid & m_sync_ready;

  spi_arb_owner_fsm i_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .req0      (s0_cmd_valid),
    .req1      (s1_cmd_valid),
    .sync_done (sync_done),
    .owner_q   (owner_q)
  );

  spi_arb_fwd_mux #(.W(CMD_W)) i_cmd_mux (
    .sel0      (sel0),
    .sel1      (sel1),
    .in0_valid (s0_cmd_valid),
    .in0_ready (s0_cmd_ready),
    .in0_data  (s0_cmd_data),
    .in1_valid (s1_cmd_valid),
    .in1_ready (s1_cmd_ready),
    .in1_data  (s1_cmd_data),
    .out_valid (m_cmd_valid),
    .out_ready (m_cmd_ready),
    .out_data  (m_cmd_data)
  );

  spi_arb_fwd_mux #(.W(SDO_W)) i_sdo_mux (
    .sel0      (sel0),
    .sel1      (sel1),
    .in0_valid (s0_sdo_valid),
    .in0_ready (s0_sdo_ready),
    .in0_data  (s0_sdo_data),
    .in1_valid (s1_sdo_valid),
    .in1_ready (s1_sdo_ready),
    .in1_data  (s1_sdo_data),
    .out_valid (m_sdo_valid),
    .out_ready (m_sdo_ready),
    .out_data  (m_sdo_data)
  );

  spi_arb_ret_demux #(.W(SDI_W)) i_sdi_demux (
    .sel0       (sel0),
    .sel1       (sel1),
    .in_valid   (m_sdi_valid),
    .in_ready   (m_sdi_ready),
    .in_data    (m_sdi_data),
    .out0_valid (s0_sdi_valid),
    .out0_ready (s0_sdi_ready),
    .out0_data  (s0_sdi_data),
    .out1_valid (s1_sdi_valid),
    .out1_ready (s1_sdi_ready),
    .out1_data  (s1_sdi_data)
  );

  spi_arb_ret_demux #(.W(SYNC_W)) i_sync_demux (
    .sel0       (sel0),
    .sel1       (sel1),
    .in_valid   (m_sync_valid),
    .in_ready   (m_sync_ready),
    .in_data    (m_sync_data),
    .out0_valid (s0_sync_valid),
    .out0_ready (s0_sync_ready),
    .out0_data  (s0_sync_data),
    .out1_valid (s1_sync_valid),
    .out1_ready (s1_sync_ready),
    .out1_data  (s1_sync_data)
  );
endmodule

// File: rtl/spi_cmd_arbiter_chk.sv
module spi_cmd_arbiter_chk
  import spi_arb_pkg::*;
(
  input logic   clk,
  input logic   rst_n,
  input owner_t owner,
  input logic   s0_cmd_valid,
  input logic   s1_cmd_valid,
  input logic   s0_cmd_ready,
  input logic   s1_cmd_ready,
  input logic   s0_sdo_ready,
  input logic   s1_sdo_ready,
  input logic   m_cmd_valid,
  input logic   m_sync_valid,
  input logic   m_sync_ready,
  input logic   s0_sync_valid,
  input logic   s1_sync_valid
);
  AST_IDLE_NO_FORWARD: assert property (@(posedge clk) disable iff (!rst_n)
    (owner == OWN_NONE) |-> (!m_cmd_valid && !s0_cmd_ready && !s1_cmd_ready)); // R5
  AST_SINGLE_READY: assert property (@(posedge clk) disable iff (!rst_n)
    !(s0_sdo_ready && s1_sdo_ready) && !(s0_sync_valid && s1_sync_valid)); // R5
  AST_GRANT_S0_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (owner == OWN_NONE && s0_cmd_valid) |=> (owner == OWN_S0)); // R4
  AST_GRANT_S1_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
    (owner == OWN_NONE && !s0_cmd_valid && s1_cmd_valid) |=> (owner == OWN_S1)); // R2
  AST_RELEASE_AFTER_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    (owner != OWN_NONE && m_sync_valid && m_sync_ready) |=> (owner == OWN_NONE)); // R7
  AST_HOLD_UNTIL_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    (owner != OWN_NONE && !(m_sync_valid && m_sync_ready)) |=> $stable(owner)); // R9
  AST_SYNC_TO_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
    (owner == OWN_S1) |-> (s1_sync_valid == m_sync_valid && !s0_sync_valid)); // R6
endmodule

bind spi_cmd_arbiter spi_cmd_arbiter_chk i_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .owner         (owner_q),
  .s0_cmd_valid  (s0_cmd_valid),
  .s1_cmd_valid  (s1_cmd_valid),
  .s0_cmd_ready  (s0_cmd_ready),
  .s1_cmd_ready  (s1_cmd_ready),
  .s0_sdo_ready  (s0_sdo_ready),
  .s1_sdo_ready  (s1_sdo_ready),
  .m_cmd_valid   (m_cmd_valid),
  .m_sync_valid  (m_sync_valid),
  .m_sync_ready  (m_sync_ready),
  .s0_sync_valid (s0_sync_valid),
  .s1_sync_valid (s1_sync_valid)
);

// File: tb/test_spi_cmd_arbiter.sv
`timescale 1ns/1ps
module test_spi_cmd_arbiter;
  localparam int CMD_W = 16, SDO_W = 8, SDI_W = 8, SYNC_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic s0_cmd_valid = 0, s0_cmd_ready, s0_sdo_valid = 0, s0_sdo_ready;
  logic s0_sdi_valid, s0_sdi_ready = 0, s0_sync_valid, s0_sync_ready = 0;
  logic s1_cmd_valid = 0, s1_cmd_ready, s1_sdo_valid = 0, s1_sdo_ready;
  logic s1_sdi_valid, s1_sdi_ready = 0, s1_sync_valid, s1_sync_ready = 0;
  logic m_cmd_valid, m_cmd_ready = 1, m_sdo_valid, m_sdo_ready = 1;
  logic m_sdi_valid = 0, m_sdi_ready, m_sync_valid = 0, m_sync_ready;
  logic [CMD_W-1:0]  s0_cmd_data = '0, s1_cmd_data = '0, m_cmd_data;
  logic [SDO_W-1:0]  s0_sdo_data = '0, s1_sdo_data = '0, m_sdo_data;
  logic [SDI_W-1:0]  s0_sdi_data, s1_sdi_data, m_sdi_data = '0;
  logic [SYNC_W-1:0] s0_sync_data, s1_sync_data, m_sync_data = '0;

  int total = 0;
  int bad = 0;
  logic [CMD_W-1:0] exp_q[$];

  always #4 clk = ~clk;

  spi_cmd_arbiter i_spi_cmd_arbiter (.*);

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic settle();
    #2;
  endtask

  // scoreboard monitor: every accepted command must match the next expected word
  always @(negedge clk) begin
    if (rst_n && m_cmd_valid && m_cmd_ready) begin
      total++;
      if (exp_q.size() == 0) begin
        bad++;
        $display("FAIL R3 unexpected command actual=%0h expected=none", m_cmd_data);
      end else begin
        logic [CMD_W-1:0] e;
        e = exp_q.pop_front();
        if (m_cmd_data !== e) begin
          bad++;
          $display("FAIL R3 command order actual=%0h expected=%0h", m_cmd_data, e);
        end
      end
    end
  end

  initial begin
    #(8 * 5000);
    total++;
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R1 during reset
    repeat (3) cyc();
    settle();
    chk(s0_cmd_ready | s1_cmd_ready | s0_sdo_ready | s1_sdo_ready, 0, "R1 readies in reset");
    chk(m_cmd_valid | m_sdo_valid, 0, "R1 m valids in reset");
    cyc(); rst_n = 1'b1;
    settle();
    chk(m_cmd_valid | s0_cmd_ready | s1_cmd_ready | s0_sync_valid | s1_sync_valid, 0, "R1 idle after reset");

    // R2: s1 requests from idle
    cyc(); s1_cmd_valid = 1; s1_cmd_data = 16'h0101; exp_q.push_back(16'h0101);
    settle();
    chk(m_cmd_valid, 0, "R2 no forward in arrival cycle");
    chk(s1_cmd_ready, 0, "R2 no ready in arrival cycle");
    cyc();
    settle();
    chk(m_cmd_valid, 1, "R2 forward one cycle later");
    chk(m_cmd_data, 16'h0101, "R2 granted data");
    chk(s1_cmd_ready, 1, "R2 ready after grant");

    // R3/R5/R8: burst from owner while s0 waits
    for (int i = 0; i < 3; i++) begin
      cyc();
      s1_cmd_data = 16'h0102 + 16'(i); exp_q.push_back(16'h0102 + 16'(i));
      s0_cmd_valid = 1; s0_cmd_data = 16'h0201;
      s1_sdo_valid = 1; s1_sdo_data = 8'h5A;
      s0_sdo_valid = 1; s0_sdo_data = 8'hA5;
      m_sdi_valid = 1; m_sdi_data = 8'h3C; s0_sdi_ready = 1; s1_sdi_ready = 1;
      settle();
      chk(m_cmd_data, 16'h0102 + 16'(i), "R3 back to back burst");
      chk(s0_cmd_ready, 0, "R5 non-owner cmd ready");
    end
    chk(m_sdo_valid, 1, "R8 sdo valid passes");
    chk(m_sdo_data, 8'h5A, "R8 sdo data of owner");
    chk(s0_sdo_ready, 0, "R5 non-owner sdo ready");
    chk(s1_sdi_valid, 1, "R8 sdi valid to owner");
    chk(s1_sdi_data, 8'h3C, "R8 sdi data to owner");
    chk(s0_sdi_valid, 0, "R5 non-owner sdi valid");
    chk(m_sdi_ready, 1, "R8 sdi ready from owner");

    // R3: backpressure from engine
    cyc(); s1_cmd_data = 16'h01FF; exp_q.push_back(16'h01FF); m_cmd_ready = 0;
    settle();
    chk(s1_cmd_ready, 0, "R3 owner ready follows engine low");
    cyc(); m_cmd_ready = 1;
    settle();
    chk(s1_cmd_ready, 1, "R3 owner ready follows engine high");

    // R6/R9: sync pending without ready keeps ownership
    cyc(); s1_cmd_valid = 0; s1_sdo_valid = 0; m_sdi_valid = 0;
    m_sync_valid = 1; m_sync_data = 8'h77;
    settle();
    chk(s1_sync_valid, 1, "R6 sync valid to owner");
    chk(s1_sync_data, 8'h77, "R6 sync data to owner");
    chk(s0_sync_valid, 0, "R5 non-owner sync valid");
    chk(m_sync_ready, 0, "R6 sync ready follows owner low");
    cyc(); s1_sdo_valid = 1;
    settle();
    chk(m_sdo_valid, 1, "R9 still owned while sync waits");
    chk(s0_cmd_ready, 0, "R9 waiting source still blocked");
    s1_sync_ready = 1;
    #1;
    chk(m_sync_ready, 1, "R6 sync ready follows owner high");

    // R7: idle cycle after handshake
    cyc(); m_sync_valid = 0; s1_sync_ready = 0; s1_sdo_valid = 0;
    settle();
    chk(m_cmd_valid, 0, "R7 idle cycle after sync");
    chk(s0_cmd_ready | s0_sdo_ready, 0, "R7 no ready in idle cycle");
    cyc(); exp_q.push_back(16'h0201);
    settle();
    chk(m_cmd_valid, 1, "R7 grant after idle");
    chk(m_cmd_data, 16'h0201, "R7 granted command");
    chk(m_sdo_valid, 1, "R8 pending sdo forwarded after grant");
    chk(m_sdo_data, 8'hA5, "R8 pending sdo data");

    // same cycle: owner command + sync handshake + other source waiting
    cyc(); s0_sdo_valid = 0; s0_cmd_data = 16'h0202; exp_q.push_back(16'h0202);
    m_sync_valid = 1; s0_sync_ready = 1; s1_cmd_valid = 1; s1_cmd_data = 16'h0301;
    settle();
    chk(m_cmd_data, 16'h0202, "R6 command passes in handshake cycle");
    chk(s0_sync_valid, 1, "R6 sync to owner s0");
    chk(s1_cmd_ready, 0, "R5 s1 blocked during s0 ownership");
    cyc(); m_sync_valid = 0; s0_cmd_data = 16'h0203;
    settle();
    chk(m_cmd_valid, 0, "R7 idle after same-cycle release");
    cyc(); exp_q.push_back(16'h0203);
    settle();
    chk(m_cmd_data, 16'h0203, "R4 tie goes to s0");
    chk(s1_cmd_ready, 0, "R4 s1 loses tie");

    cyc(); s0_cmd_valid = 0; m_sync_valid = 1;
    settle();
    chk(s0_sync_valid, 1, "R6 second sync to s0");
    cyc(); m_sync_valid = 0;
    settle();
    chk(m_cmd_valid, 0, "R7 idle before s1 grant");
    cyc(); exp_q.push_back(16'h0301);
    settle();
    chk(m_cmd_valid, 1, "R7 s1 granted");
    chk(m_cmd_data, 16'h0301, "R7 s1 command");
    cyc(); s1_cmd_valid = 0;
    repeat (2) cyc();
    chk(exp_q.size(), 0, "R3 all commands delivered");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule